// File: doc/BRIEF.md
# DRAM Power-Up and CBR Refresh Sequencer

This block owns the active-low row strobe, column strobe and write-enable lines of an asynchronous fast-page-mode DRAM. It handles start-up and keeps the array refreshed. After reset it keeps every strobe inactive for a programmable number of clocks. It then runs a fixed train of wake-up cycles. Each wake-up cycle is either a row-strobe-only refresh or a column-before-row refresh with write-enable held high. These are the only cycle kinds that also bring the device out of its vendor test state if it powered up in that state. Once the train has finished, the block raises `ready` and begins to service an internal refresh interval timer with column-before-row refresh cycles.

The block never drives write-enable low, so a refresh cycle can never select the device's test mode. `refresh_due` and `refresh_busy` are plain status levels for the arbiter that shares the strobes with the data path. While `refresh_busy` is high, the arbiter must leave the strobes alone. No data flows through this block, so it has no valid/ready stream interface. Every phase length is a parameter counted in clocks. At 200 MHz, the default power-up delay of 20000 clocks equals 100 µs.

Top module: `dram_refresh_seq`

## Requirements
- R1: While reset is asserted and for the first PWRUP_CYCLES clocks after it is released, `ras_n`, `cas_n` and `we_n` are all 1, `ready` is 0 and `refresh_busy` is 1. The first strobe activity appears on clock PWRUP_CYCLES+1 after release.
- R2: Exactly WAKE_CYCLES (8) row-strobe falls occur before `ready` rises. `ready` rises on the idle clock that follows the eighth cycle's precharge, and it stays 1 until the next reset.
- R3: A wake-up cycle is a row-only cycle when WAKE_CBR is 0: `ras_n` goes low while `cas_n` and `we_n` stay 1. When WAKE_CBR is 1, the wake-up cycle is a column-before-row cycle.
- R4: In a column-before-row cycle, `cas_n` falls alone and stays low for T_CSR clocks before `ras_n` falls. Both then stay low for T_RAS clocks and rise on the same clock.
- R5: `we_n` is 1 on every clock, so it is never 0 while `cas_n` is 0 ahead of `ras_n`.
- R6: `ras_n` stays low for exactly T_RAS clocks. Each cycle then keeps all strobes at 1 for T_RP precharge clocks plus one idle clock before the next cycle can begin.
- R7: Counting starts on the clock after the power-up delay ends. The interval timer then sets `refresh_due` every REFRESH_INTERVAL clocks. `refresh_due` stays 1 until the column-before-row refresh that serves it completes its precharge. It falls on the following idle clock, unless a new interval expires on that same clock.
- R8: A request that expires during the wake-up train, or during a cycle, is held. If `refresh_due` is 1 when `ready` rises, the refresh begins with a `cas_n` fall on the clock right after `ready` rises.
- R9: `refresh_busy` is 1 whenever `ready` is 0, whenever any strobe is 0, or whenever `refresh_due` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready | output | 1 | Power-up sequence finished; memory usable |
| refresh_due | output | 1 | A refresh interval has expired and is not yet served |
| refresh_busy | output | 1 | Strobes owned by the sequencer; arbiter must hold off |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low (always driven high) |

## Verification
The hardest case to reach from the ports is a refresh interval that expires while the wake-up train is still running. That request must be held back and then served at once when `ready` rises. The bench sets REFRESH_INTERVAL shorter than the whole power-up delay plus train, so the first expiry falls inside the train. The bench's cycle model then predicts the refresh that follows `ready` on the next clock. Separate monitors measure the length of the quiet delay, count row-strobe falls before `ready`, and time the column-to-row lead of every column-before-row edge pair against write-enable.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CSR  = 2'd1,
    PH_ACT  = 2'd2,
    PH_PRE  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    M_DELAY = 2'd0,
    M_WAKE  = 2'd1,
    M_RUN   = 2'd2
  } mode_e;

  typedef enum logic {
    K_RAS_ONLY = 1'b0,
    K_CBR      = 1'b1
  } cyc_kind_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dram_pwrup_timer.sv
module dram_pwrup_timer #(
  parameter int PWRUP_CYCLES = 20000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired_o
);
  localparam int DW = $clog2(PWRUP_CYCLES + 1);
  localparam logic [DW-1:0] LOAD = DW'(PWRUP_CYCLES - 1);

  logic [DW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= LOAD;
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign expired_o = (left_q == '0);
endmodule

// File: rtl/dram_rfsh_timer.sv
module dram_rfsh_timer #(
  parameter int REFRESH_INTERVAL = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic served_i,
  output logic due_o
);
  localparam int RW = $clog2(REFRESH_INTERVAL + 1);
  localparam logic [RW-1:0] LAST = RW'(REFRESH_INTERVAL - 1);

  logic [RW-1:0] tick_q;
  logic          due_q;
  logic          wrap;

  assign wrap = run_i && (tick_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      due_q  <= 1'b0;
    end else begin
      if (wrap) begin
        tick_q <= '0;
      end else if (run_i) begin
        tick_q <= tick_q + 1'b1;
      end
      if (wrap) begin
        due_q <= 1'b1;
      end else if (served_i) begin
        due_q <= 1'b0;
      end
    end
  end

  assign due_o = due_q;
endmodule

// File: rtl/dram_strobe_engine.sv
module dram_strobe_engine
  import dram_seq_pkg::*;
#(
  parameter int T_CSR = 2,
  parameter int T_RAS = 20,
  parameter int T_RP  = 18
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  cyc_kind_e kind_i,
  output logic      idle_o,
  output logic      done_o,
  output logic      ras_n_o,
  output logic      cas_n_o,
  output logic      we_n_o
);
  localparam int TMAX = max3(T_CSR, T_RAS, T_RP);
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] LD_CSR = CW'(T_CSR - 1);
  localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  cyc_kind_e     kind_q, kind_d;
  logic          ras_q, cas_q, we_q;
  logic          zero;

  assign zero = (cnt_q == '0);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          kind_d = kind_i;
          if (kind_i == K_CBR) begin
            ph_d  = PH_CSR;
            cnt_d = LD_CSR;
          end else begin
            ph_d  = PH_ACT;
            cnt_d = LD_RAS;
          end
        end
      end
      PH_CSR: begin
        if (zero) begin
          ph_d  = PH_ACT;
          cnt_d = LD_RAS;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACT: begin
        if (zero) begin
          ph_d  = PH_PRE;
          cnt_d = LD_RP;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_PRE: begin
        if (zero) begin
          ph_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      kind_q <= K_RAS_ONLY;
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      ras_q  <= (ph_d != PH_ACT);
      cas_q  <= !((ph_d == PH_CSR) || ((ph_d == PH_ACT) && (kind_d == K_CBR)));
      // write enable is never asserted: a column-first cycle with it low selects test mode
      we_q   <= 1'b1;
    end
  end

  assign idle_o  = (ph_q == PH_IDLE);
  assign done_o  = (ph_q == PH_PRE) && zero;
  assign ras_n_o = ras_q;
  assign cas_n_o = cas_q;
  assign we_n_o  = we_q;
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_seq_pkg::*;
#(
  parameter int PWRUP_CYCLES     = 20000,
  parameter int WAKE_CYCLES      = 8,
  parameter int WAKE_CBR         = 0,
  parameter int T_CSR            = 2,
  parameter int T_RAS            = 20,
  parameter int T_RP             = 18,
  parameter int REFRESH_INTERVAL = 3120
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready,
  output logic refresh_due,
  output logic refresh_busy,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam logic [WW-1:0] WLAST = WW'(WAKE_CYCLES - 1);

  mode_e         mode_q;
  logic [WW-1:0] wakes_q;
  logic          dly_done, eng_idle, eng_done, eng_start, due;
  cyc_kind_e     wake_kind, eng_kind;

  generate
    if (WAKE_CBR != 0) begin : g_wake_cbr
      assign wake_kind = K_CBR;
    end else begin : g_wake_rasonly
      assign wake_kind = K_RAS_ONLY;
    end
  endgenerate

  dram_pwrup_timer #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_pwrup (
    .clk       (clk),
    .rst_n     (rst_n),
    .expired_o (dly_done)
  );

  dram_rfsh_timer #(.REFRESH_INTERVAL(REFRESH_INTERVAL)) u_rfsh (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (mode_q != M_DELAY),
    .served_i ((mode_q == M_RUN) && eng_done),
    .due_o    (due)
  );

  assign eng_start = eng_idle &&
                     (((mode_q == M_WAKE) && (wakes_q < WW'(WAKE_CYCLES))) ||
                      ((mode_q == M_RUN) && due));
  assign eng_kind  = (mode_q == M_WAKE) ? wake_kind : K_CBR;

  dram_strobe_engine #(.T_CSR(T_CSR), .T_RAS(T_RAS), .T_RP(T_RP)) u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (eng_start),
    .kind_i  (eng_kind),
    .idle_o  (eng_idle),
    .done_o  (eng_done),
    .ras_n_o (ras_n),
    .cas_n_o (cas_n),
    .we_n_o  (we_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_DELAY;
      wakes_q <= '0;
    end else begin
      unique case (mode_q)
        M_DELAY: if (dly_done) mode_q <= M_WAKE;
        M_WAKE: begin
          if (eng_done) begin
            wakes_q <= wakes_q + 1'b1;
            if (wakes_q == WLAST) mode_q <= M_RUN;
          end
        end
        M_RUN:   mode_q <= M_RUN;
        default: mode_q <= M_DELAY;
      endcase
    end
  end

  assign ready        = (mode_q == M_RUN);
  assign refresh_due  = due;
  assign refresh_busy = (mode_q != M_RUN) || !eng_idle || due;
endmodule

// File: rtl/dram_seq_checker.sv
module dram_seq_checker #(
  parameter int PWRUP_CYCLES = 20000,
  parameter int WAKE_CYCLES  = 8,
  parameter int WAKE_CBR     = 0
) (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic refresh_due,
  input logic refresh_busy,
  input logic ras_n,
  input logic cas_n,
  input logic we_n
);
  localparam int CW = $clog2(PWRUP_CYCLES + 2);
  localparam int FW = $clog2(WAKE_CYCLES + 2) + 1;

  logic [CW-1:0] since_rst;
  logic [FW-1:0] falls;
  logic          ras_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
      falls     <= '0;
      ras_prev  <= 1'b1;
    end else begin
      if (since_rst <= CW'(PWRUP_CYCLES)) since_rst <= since_rst + 1'b1;
      ras_prev <= ras_n;
      if (ras_prev && !ras_n && !ready && (falls != '1)) falls <= falls + 1'b1;
    end
  end

  p_quiet_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= CW'(PWRUP_CYCLES)) |-> (ras_n && cas_n && we_n && !ready));

  p_wake_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (falls == FW'(WAKE_CYCLES)));

  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  p_wake_kind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !cas_n) |-> (WAKE_CBR != 0));

  p_cas_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n));

  p_cas_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> (ras_n && $past(!ras_n)));

  p_we_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cas_n || !ras_n) |-> we_n);

  p_due_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refresh_due) |-> (ready && ras_n && cas_n));

  p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !cas_n || refresh_due || !ready) |-> refresh_busy);
endmodule

bind dram_refresh_seq dram_seq_checker #(
  .PWRUP_CYCLES (PWRUP_CYCLES),
  .WAKE_CYCLES  (WAKE_CYCLES),
  .WAKE_CBR     (WAKE_CBR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ready        (ready),
  .refresh_due  (refresh_due),
  .refresh_busy (refresh_busy),
  .ras_n        (ras_n),
  .cas_n        (cas_n),
  .we_n         (we_n)
);

// File: tb/tb_dram_refresh_seq.sv
`timescale 1ns/1ps
module tb_dram_refresh_seq;
  localparam int PWRUP = 200;
  localparam int NWAKE = 8;
  localparam int WCBR  = 0;
  localparam int TCSR  = 2;
  localparam int TRAS  = 4;
  localparam int TRP   = 3;
  localparam int RI    = 60;
  localparam int LAST_K = 700;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ready, refresh_due, refresh_busy, ras_n, cas_n, we_n;

  always #2.5 clk = ~clk;

  dram_refresh_seq #(
    .PWRUP_CYCLES(PWRUP), .WAKE_CYCLES(NWAKE), .WAKE_CBR(WCBR),
    .T_CSR(TCSR), .T_RAS(TRAS), .T_RP(TRP), .REFRESH_INTERVAL(RI)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ready(ready), .refresh_due(refresh_due),
    .refresh_busy(refresh_busy), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int  nchk = 0;
  int  nfail = 0;
  bit  finished = 0;
  int  k = 0;

  // reference model: queued strobe timeline plus integer bookkeeping
  bit q_ras[$];
  bit q_cas[$];
  int q_tag[$];  // 0 busy, 1 idle, 2 wake end, 3 refresh end, 4 last wake end
  int mode = 0;  // 0 delay, 1 wake, 2 run
  int wakes = 0;
  bit pend = 0;

  int  first_fall = 0;
  int  falls_before_ready = 0;
  int  cas_before_ready = 0;
  int  cas_fall_k = -1;
  int  ready_k = 0;
  int  first_rfsh_k = 0;
  bit  ras_p = 1, cas_p = 1, ready_p = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d (clock %0d)", req, what, act, exp, k);
    end
  endtask

  task automatic push_cycle(input bit cbr, input int tend);
    if (cbr) for (int i = 0; i < TCSR; i++) begin q_ras.push_back(1); q_cas.push_back(0); q_tag.push_back(0); end
    for (int i = 0; i < TRAS; i++) begin q_ras.push_back(0); q_cas.push_back(!cbr); q_tag.push_back(0); end
    for (int i = 0; i < TRP; i++) begin q_ras.push_back(1); q_cas.push_back(1); q_tag.push_back(0); end
    q_ras.push_back(1); q_cas.push_back(1); q_tag.push_back(tend);
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit er, ec;
      int et;
      k++;
      if (q_ras.size() > 0) begin
        er = q_ras.pop_front(); ec = q_cas.pop_front(); et = q_tag.pop_front();
      end else begin
        er = 1; ec = 1; et = 1;
      end
      if (k == PWRUP) mode = 1;
      if (et == 4) mode = 2;
      if (et == 3) pend = 0;
      if (k > PWRUP && ((k - PWRUP) % RI) == 0) pend = 1;
      if (et != 0) begin
        if (mode == 1 && wakes < NWAKE) begin
          push_cycle(WCBR != 0, (wakes == NWAKE - 1) ? 4 : 2);
          wakes++;
        end else if (mode == 2 && pend) begin
          push_cycle(1'b1, 3);
        end
      end
      check("R6", "ras_n", ras_n, er);
      check("R4", "cas_n", cas_n, ec);
      check("R5", "we_n", we_n, 1);
      check("R2", "ready", ready, mode == 2);
      check("R7", "refresh_due", refresh_due, pend);
      check("R9", "refresh_busy", refresh_busy, (mode != 2) || (et == 0) || pend);

      // edge monitors
      if (ras_p && !ras_n) begin
        if (first_fall == 0) first_fall = k;
        if (!ready) falls_before_ready++;
        if (!cas_n && cas_fall_k >= 0) check("R4", "column lead clocks", k - cas_fall_k, TCSR);
      end
      if (cas_p && !cas_n && ras_n) begin
        cas_fall_k = k;
        check("R5", "we_n at column-first fall", we_n, 1);
        if (ready && first_rfsh_k == 0) first_rfsh_k = k;
      end
      if (!cas_n && !ready) cas_before_ready++;
      if (!ready_p && ready) ready_k = k;
      ras_p = ras_n; cas_p = cas_n; ready_p = ready;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "reset ras_n", ras_n, 1);
    check("R1", "reset cas_n", cas_n, 1);
    check("R1", "reset we_n", we_n, 1);
    check("R1", "reset ready", ready, 0);
    check("R1", "reset busy", refresh_busy, 1);
    #1 rst_n = 1'b1;
    wait (k >= LAST_K);
    @(posedge clk);
    check("R1", "first strobe clock", first_fall, PWRUP + 1);
    check("R2", "row falls before ready", falls_before_ready, NWAKE);
    check("R2", "ready clock", ready_k, PWRUP + NWAKE * (TRAS + TRP + 1));
    check("R3", "column lows during wake", cas_before_ready, 0);
    check("R8", "deferred refresh start", first_rfsh_k, ready_k + 1);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule